// File: doc/BRIEF.md
# MII Receive Status and Error Signalling

This block is the per-port receive-side status stage of a 10/100 Ethernet PHY's media-independent interface. It takes the decoded nibble stream, its valid flag and a set of error-class flags from the symbol decoder. From these it drives the registered receive outputs: data valid, error and the four data bits. When a 100 Mb/s error is flagged, it replaces the data nibble with a code that identifies the class of the error. Two further outputs are purely combinational: carrier sense and collision. They are formed from transmit enable and line receive activity.

Two alternative modes reuse the same pins. In 10 Mb/s serial mode, one data bit leaves on the lowest data line and the upper three lines are released. The collision pin then reports that the jabber timer has expired. In 100 Mb/s decoder-bypass mode, the error pin carries a fifth data bit.

A small state machine selects which of these behaviours is loaded into the output register on each receive clock. It has five states:

- ST_IDLE: no valid data.
- ST_DATA: a valid nibble.
- ST_ERROR: an error code.
- ST_SERIAL: 10 Mb/s serial mode.
- ST_BYPASS: 5-bit bypass mode.

The next state is computed every cycle from the inputs, using this priority:

1. ST_SERIAL when serial is selected at 10 Mb/s.
2. ST_BYPASS when bypass is selected at 100 Mb/s.
3. ST_ERROR when a qualified error is flagged at 100 Mb/s.
4. ST_DATA when the valid flag is high.
5. ST_IDLE otherwise.

Any state can therefore move to any other state in a single cycle.

Top module: `mii_rx_status`

## Requirements
- R1: In half duplex, outside serial 10 Mb/s mode, `col` equals `tx_en AND rx_active`, combinationally and in the same cycle.
- R2: With `full_duplex` high, outside serial 10 Mb/s mode, `col` is low.
- R3: With `crs_rx_only` low, `crs` equals `tx_en OR rx_active`, so it stays high through any collision. With `crs_rx_only` high, `crs` equals `rx_active`.
- R4: At 100 Mb/s in normal mode, a flagged error sets `rx_er` high and places a code on `rxd`. The codes are 4'h5 for a code error, 4'h4 for a premature end, 4'h3 for a link error and 4'h2 for a packet error. When several errors are flagged together, they are chosen in that priority order.
- R5: A link error produces code 4'h3 only while `link_err_en` is high, and a packet error produces code 4'h2 only while `pkt_err_en` is high. With its enable low, the flag alone leaves `rx_er` low and `rxd` carrying data.
- R6: Serial mode applies when `serial_mode` is high and `speed_100` is low. In it:
  - `rxd[0]` carries `serial_bit`;
  - `rxd[3:1]` are 0 with `rxd_oe` = 4'b0001 (upper lines released);
  - `rx_dv` and `rx_er` are low.
- R7: In serial 10 Mb/s mode, `col` equals `jabber_expired`.
- R8: Bypass mode applies when `bypass` is high and `speed_100` is high, outside serial mode. In it, `rx_er` carries `dec_bit4`, `rxd` carries `dec_nibble` and `rx_dv` carries `dec_valid`. Bypass has no effect at 10 Mb/s, and `serial_mode` has no effect at 100 Mb/s.
- R9: `rx_dv`, `rx_er`, `rxd` and `rxd_oe` change only on the rising edge of `clk`, one cycle after the inputs that produce them.
- R10: While `rst_n` is low at a rising edge, `rx_dv`, `rx_er` and `rxd` are cleared to 0 and `rxd_oe` is set to 4'b1111.
- R11: In 10 Mb/s nibble mode, `rx_er` stays low and no error code replaces the data.
- R12: With no qualified error, `rxd` carries `dec_nibble` when `dec_valid` is high and 0 otherwise, and `rx_dv` follows `dec_valid`. In all non-serial modes, `rxd_oe` is 4'b1111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | 1 | Full-duplex operation |
| serial_mode | input | 1 | Serial 10 Mb/s select |
| bypass | input | 1 | 5-bit decoder bypass select |
| crs_rx_only | input | 1 | Carrier sense from receive activity only |
| pkt_err_en | input | 1 | Enable packet-error code |
| link_err_en | input | 1 | Enable link-error code |
| tx_en | input | 1 | Transmit enable |
| rx_active | input | 1 | Receive activity on the line |
| jabber_expired | input | 1 | Jabber timer expired |
| dec_valid | input | 1 | Decoder nibble valid |
| dec_nibble | input | 4 | Decoded nibble |
| dec_bit4 | input | 1 | Fifth bit in bypass mode |
| serial_bit | input | 1 | Serial receive bit |
| err_code | input | 1 | Code error flag |
| err_premature | input | 1 | Premature end flag |
| err_link | input | 1 | Link error flag |
| err_packet | input | 1 | Packet error flag |
| col | output | 1 | Collision or jabber indication |
| crs | output | 1 | Carrier sense |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error or fifth data bit |
| rxd | output | 4 | Receive data or error code |
| rxd_oe | output | 4 | Per-line output enable of rxd |

## Verification
The hardest situation to reach is several error flags raised together while the link and packet enables are in mixed settings. Only that combination shows whether the priority order holds and whether a disabled class falls through to data rather than to a lower code. The stimulus table therefore walks flag sets from all four flags down to a single one, and pairs each gated flag with its own enable both on and off. It also sets the mode bits in their invalid pairings, serial at 100 Mb/s and bypass at 10 Mb/s, to show that those bits are ignored.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
    localparam int NIB_W = 4;
    typedef logic [NIB_W-1:0] nib_t;

    localparam nib_t CODE_PKT  = 4'h2;
    localparam nib_t CODE_LINK = 4'h3;
    localparam nib_t CODE_PREM = 4'h4;
    localparam nib_t CODE_SYM  = 4'h5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_ERROR,
        ST_SERIAL,
        ST_BYPASS
    } rx_state_e;

    typedef struct packed {
        logic sym;
        logic prem;
        logic link;
        logic pkt;
    } err_flags_t;
endpackage

// File: rtl/mii_rx_carrier.sv
module mii_rx_carrier (
    input  logic tx_en,
    input  logic rx_active,
    input  logic full_duplex,
    input  logic serial10,
    input  logic jabber_expired,
    input  logic crs_rx_only,
    output logic col,
    output logic crs
);
    always_comb begin
        if (serial10)
            col = jabber_expired;
        else if (full_duplex)
            col = 1'b0;
        else
            col = tx_en & rx_active;
    end

    assign crs = crs_rx_only ? rx_active : (tx_en | rx_active);
endmodule

// File: rtl/mii_rx_errsel.sv
module mii_rx_errsel
    import mii_rx_pkg::*;
(
    input  err_flags_t flags,
    input  logic       link_en,
    input  logic       pkt_en,
    output logic       hit,
    output nib_t       code
);
    // fixed priority: code error, premature end, link, packet
    always_comb begin
        hit  = 1'b1;
        code = CODE_SYM;
        if (flags.sym)
            code = CODE_SYM;
        else if (flags.prem)
            code = CODE_PREM;
        else if (flags.link && link_en)
            code = CODE_LINK;
        else if (flags.pkt && pkt_en)
            code = CODE_PKT;
        else begin
            hit  = 1'b0;
            code = '0;
        end
    end
endmodule

// File: rtl/mii_rx_status.sv
module mii_rx_status
    import mii_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             speed_100,
    input  logic             full_duplex,
    input  logic             serial_mode,
    input  logic             bypass,
    input  logic             crs_rx_only,
    input  logic             pkt_err_en,
    input  logic             link_err_en,
    input  logic             tx_en,
    input  logic             rx_active,
    input  logic             jabber_expired,
    input  logic             dec_valid,
    input  logic [NIB_W-1:0] dec_nibble,
    input  logic             dec_bit4,
    input  logic             serial_bit,
    input  logic             err_code,
    input  logic             err_premature,
    input  logic             err_link,
    input  logic             err_packet,
    output logic             col,
    output logic             crs,
    output logic             rx_dv,
    output logic             rx_er,
    output logic [NIB_W-1:0] rxd,
    output logic [NIB_W-1:0] rxd_oe
);
    localparam nib_t OE_SERIAL = nib_t'(1);
    localparam nib_t OE_ALL    = '1;

    logic       serial10;
    logic       bypass100;
    logic       err_hit;
    nib_t       err_nib;
    err_flags_t flags;
    rx_state_e  state_q;
    rx_state_e  state_d;

    assign serial10  = serial_mode & ~speed_100;
    assign bypass100 = bypass & speed_100;
    assign flags     = '{sym: err_code, prem: err_premature, link: err_link, pkt: err_packet};

    mii_rx_carrier u_carrier (
        .tx_en          (tx_en),
        .rx_active      (rx_active),
        .full_duplex    (full_duplex),
        .serial10       (serial10),
        .jabber_expired (jabber_expired),
        .crs_rx_only    (crs_rx_only),
        .col            (col),
        .crs            (crs)
    );

    mii_rx_errsel u_errsel (
        .flags   (flags),
        .link_en (link_err_en),
        .pkt_en  (pkt_err_en),
        .hit     (err_hit),
        .code    (err_nib)
    );

    // next-state selection, mode before error before data
    always_comb begin
        if (serial10)
            state_d = ST_SERIAL;
        else if (bypass100)
            state_d = ST_BYPASS;
        else if (speed_100 && err_hit)
            state_d = ST_ERROR;
        else if (dec_valid)
            state_d = ST_DATA;
        else
            state_d = ST_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_dv  <= 1'b0;
            rx_er  <= 1'b0;
            rxd    <= '0;
            rxd_oe <= OE_ALL;
        end else begin
            unique case (state_d)
                ST_SERIAL: begin
                    rx_dv  <= 1'b0;
                    rx_er  <= 1'b0;
                    rxd    <= {{(NIB_W-1){1'b0}}, serial_bit};
                    rxd_oe <= OE_SERIAL;
                end
                ST_BYPASS: begin
                    rx_dv  <= dec_valid;
                    rx_er  <= dec_bit4;
                    rxd    <= dec_nibble;
                    rxd_oe <= OE_ALL;
                end
                ST_ERROR: begin
                    rx_dv  <= dec_valid;
                    rx_er  <= 1'b1;
                    rxd    <= err_nib;
                    rxd_oe <= OE_ALL;
                end
                ST_DATA: begin
                    rx_dv  <= 1'b1;
                    rx_er  <= 1'b0;
                    rxd    <= dec_nibble;
                    rxd_oe <= OE_ALL;
                end
                default: begin
                    rx_dv  <= 1'b0;
                    rx_er  <= 1'b0;
                    rxd    <= '0;
                    rxd_oe <= OE_ALL;
                end
            endcase
        end
    end

    p_col_and_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_duplex && !serial10) |-> (col == (tx_en && rx_active)));

    p_col_fdx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full_duplex && !serial10) |-> !col);

    p_crs_rxonly_r3: assert property (@(posedge clk) disable iff (!rst_n)
        crs_rx_only |-> (crs == rx_active));

    p_crs_in_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (col && !serial10 && !crs_rx_only) |-> crs);

    p_err_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && rx_er && state_q == ST_ERROR)
            |-> (rxd >= CODE_PKT && rxd <= CODE_SYM));

    p_serial_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERIAL) |-> (rxd_oe == OE_SERIAL && !rx_dv && !rx_er));

    p_col_jabber_r7: assert property (@(posedge clk) disable iff (!rst_n)
        serial10 |-> (col == jabber_expired));

    p_no_er_10m_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(speed_100)) |-> !rx_er);
endmodule

// File: tb/sim_mii_rx_status.sv
module sim_mii_rx_status;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, speed_100, full_duplex, serial_mode, bypass, crs_rx_only;
    logic pkt_err_en, link_err_en, tx_en, rx_active, jabber_expired;
    logic dec_valid, dec_bit4, serial_bit;
    logic err_code, err_premature, err_link, err_packet;
    logic [3:0] dec_nibble;
    logic col, crs, rx_dv, rx_er;
    logic [3:0] rxd, rxd_oe;

    mii_rx_status u0 (
        .clk(clk), .rst_n(rst_n), .speed_100(speed_100), .full_duplex(full_duplex),
        .serial_mode(serial_mode), .bypass(bypass), .crs_rx_only(crs_rx_only),
        .pkt_err_en(pkt_err_en), .link_err_en(link_err_en), .tx_en(tx_en),
        .rx_active(rx_active), .jabber_expired(jabber_expired), .dec_valid(dec_valid),
        .dec_nibble(dec_nibble), .dec_bit4(dec_bit4), .serial_bit(serial_bit),
        .err_code(err_code), .err_premature(err_premature), .err_link(err_link),
        .err_packet(err_packet), .col(col), .crs(crs), .rx_dv(rx_dv), .rx_er(rx_er),
        .rxd(rxd), .rxd_oe(rxd_oe)
    );

    // field order: spd fdx ser byp crsro pen len txen rxact jab dv b4 sb ec epre elink epkt nib
    typedef struct packed {
        logic spd, fdx, ser, byp, crsro, pen, len, txen, rxact, jab;
        logic dv, b4, sb, ec, epre, elink, epkt;
        logic [3:0] nib;
    } stim_t;

    localparam int N = 17;
    localparam stim_t TBL [0:N-1] = '{
        21'b1_0_0_0_0_0_0_0_1_0_1_0_0_0_0_0_0_1010, // 100 data
        21'b1_0_0_0_0_0_0_1_1_0_1_0_0_0_0_0_0_0011, // half-duplex collision
        21'b1_1_0_0_0_0_0_1_1_0_1_0_0_0_0_0_0_0011, // full duplex
        21'b1_0_0_0_1_0_0_1_0_0_0_0_0_0_0_0_0_0000, // crs rx-only, tx only
        21'b1_0_0_0_0_0_0_0_1_0_1_0_0_1_0_0_0_1001, // code error
        21'b1_0_0_0_0_1_1_0_1_0_1_0_0_1_1_1_1_1111, // all flags
        21'b1_0_0_0_0_1_1_0_1_0_1_0_0_0_1_1_1_1111, // premature+link+pkt
        21'b1_0_0_0_0_1_1_0_1_0_1_0_0_0_0_1_1_1111, // link+pkt
        21'b1_0_0_0_0_1_1_0_1_0_1_0_0_0_0_0_1_1111, // pkt only
        21'b1_0_0_0_0_1_0_0_1_0_1_0_0_0_0_1_0_0110, // link flag, link disabled
        21'b1_0_0_0_0_0_1_0_1_0_1_0_0_0_0_0_1_1100, // pkt flag, pkt disabled
        21'b0_0_0_0_0_0_0_0_1_0_1_0_0_1_1_0_0_1011, // 10 nibble with errors
        21'b0_0_1_0_0_0_0_1_1_1_1_0_1_0_0_0_0_1110, // serial, jabber
        21'b0_0_1_0_0_0_0_1_1_0_1_0_0_1_0_0_0_1110, // serial, no jabber
        21'b1_0_0_1_0_0_0_0_1_0_1_1_0_1_0_0_0_0110, // bypass
        21'b0_0_0_1_0_0_0_0_1_0_1_1_0_0_0_0_0_0101, // bypass at 10: ignored
        21'b1_0_1_0_0_0_0_1_1_1_1_0_1_0_0_0_0_0111  // serial at 100: ignored
    };

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply(input stim_t s);
        speed_100 = s.spd; full_duplex = s.fdx; serial_mode = s.ser; bypass = s.byp;
        crs_rx_only = s.crsro; pkt_err_en = s.pen; link_err_en = s.len;
        tx_en = s.txen; rx_active = s.rxact; jabber_expired = s.jab;
        dec_valid = s.dv; dec_bit4 = s.b4; serial_bit = s.sb;
        err_code = s.ec; err_premature = s.epre; err_link = s.elink; err_packet = s.epkt;
        dec_nibble = s.nib;
    endtask

    // reference model written from the requirements
    task automatic model(input stim_t s, output logic m_col, output logic m_crs,
                         output logic m_dv, output logic m_er,
                         output logic [3:0] m_rxd, output logic [3:0] m_oe);
        logic s10;
        s10 = s.ser && !s.spd;
        m_col = s10 ? s.jab : (s.fdx ? 1'b0 : (s.txen && s.rxact));
        m_crs = s.crsro ? s.rxact : (s.txen || s.rxact);
        m_oe  = 4'b1111;
        if (s10) begin
            m_dv = 1'b0; m_er = 1'b0; m_rxd = {3'b000, s.sb}; m_oe = 4'b0001;
        end else if (s.byp && s.spd) begin
            m_dv = s.dv; m_er = s.b4; m_rxd = s.nib;
        end else begin
            m_dv = s.dv; m_er = 1'b1;
            if (s.spd && s.ec)                 m_rxd = 4'h5;
            else if (s.spd && s.epre)          m_rxd = 4'h4;
            else if (s.spd && s.elink && s.len) m_rxd = 4'h3;
            else if (s.spd && s.epkt && s.pen)  m_rxd = 4'h2;
            else begin
                m_er = 1'b0; m_rxd = s.dv ? s.nib : 4'h0;
            end
        end
    endtask

    function automatic string data_tag(input stim_t s);
        if (s.ser && !s.spd)  return "R6";
        if (s.byp && s.spd)   return "R8";
        if (!s.spd)           return "R11";
        if (s.ec || s.epre)   return "R4";
        if (s.elink || s.epkt) return "R5";
        return "R12";
    endfunction

    initial begin
        #(4 * 200000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic m_col, m_crs, m_dv, m_er;
        logic [3:0] m_rxd, m_oe;
        stim_t s;
        rst_n = 1'b0;
        apply(TBL[0]);
        repeat (3) @(posedge clk);
        #1;
        chk("R10 dv", rx_dv, 0);
        chk("R10 er", rx_er, 0);
        chk("R10 rxd", rxd, 0);
        chk("R10 oe", rxd_oe, 4'hF);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            s = TBL[i];
            apply(s);
            model(s, m_col, m_crs, m_dv, m_er, m_rxd, m_oe);
            #1;
            chk((s.ser && !s.spd) ? "R7 col" : (s.fdx ? "R2 col" : "R1 col"), col, m_col);
            chk("R3 crs", crs, m_crs);
            @(posedge clk);
            #1;
            chk({data_tag(s), " rxd"}, rxd, m_rxd);
            chk({data_tag(s), " dv"}, rx_dv, m_dv);
            chk({data_tag(s), " er"}, rx_er, m_er);
            chk({data_tag(s), " oe"}, rxd_oe, m_oe);
        end

        // R9: outputs hold until the next rising edge
        @(negedge clk);
        apply(TBL[0]);
        @(posedge clk); #1;
        chk("R9 first", rxd, 4'hA);
        @(negedge clk);
        s = TBL[0]; s.nib = 4'h5;
        apply(s);
        #1;
        chk("R9 hold rxd", rxd, 4'hA);
        @(posedge clk); #1;
        chk("R9 update rxd", rxd, 4'h5);

        // R3: crs stays up through a collision, tx side only
        @(negedge clk);
        s = TBL[1]; s.rxact = 1'b0;
        apply(s);
        #1;
        chk("R3 tx only crs", crs, 1);
        chk("R1 tx only col", col, 0);

        // R10: reset in the middle of an error frame
        @(negedge clk);
        apply(TBL[5]);
        @(posedge clk); #1;
        chk("R4 before reset", rxd, 4'h5);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R10 mid rxd", rxd, 0);
        chk("R10 mid er", rx_er, 0);
        chk("R10 mid dv", rx_dv, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R4 after reset", rxd, 4'h5);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule